// File: doc/BRIEF.md
# Byte Memory Transfer Engine

This block moves words between an 8-bit external byte memory and an internal word memory while the host processor keeps running. Software sets up a 22-bit byte address, an internal word address, a direction, a word width and a wait-state count through a small register write port. Writing a nonzero word count starts the transfer.

Each word is handled as two bytes (16-bit words) or three bytes (24-bit words), most significant byte first. Every byte access on the external bus is held for the programmed number of wait states plus one cycle. Inbound bytes are packed into an internal word write. Outbound words are read from internal memory, which returns data one cycle after a read request, and are then split into bytes. When the count reaches zero the block raises a one-cycle interrupt. Writing a zero count stops a transfer at once, and no interrupt follows.

Top module: `bytemem_xfer`

## Requirements
- R1: After reset the block is idle: busy, irq, ext_rd, ext_wr, mem_re and mem_we are low, and words_left is zero.
- R2: A register write with reg_sel = 4 and nonzero data loads the word count. If the block is idle, the transfer starts on the next cycle. busy stays high until the count reaches zero, and words_left shows the remaining word count.
- R3: Each byte access holds its strobe and ext_addr for W+1 cycles, where W is the wait count (reg_sel = 3). Control bit 0 (reg_sel = 2) selects the direction: 0 moves data from byte memory to internal memory with ext_rd, and 1 moves data from internal memory to byte memory with ext_wr. ext_rd and ext_wr are never high together.
- R4: Inbound, control bit 1 set packs three bytes into a 24-bit word, first byte in bits 23:16. Control bit 1 clear packs two bytes into bits 15:0 with bits 23:16 zero.
- R5: Outbound, each internal word is sent most significant byte first: bits 23:16, 15:8, 7:0 for 24-bit words, and bits 15:8, 7:0 for 16-bit words.
- R6: The byte address (reg_sel = 0, 22 bits) advances by one after each byte, including its upper bits. The internal address (reg_sel = 1) advances by one after each word. Nothing outside the range is touched.
- R7: When the last word completes, irq is high for exactly one cycle, busy is low and words_left is zero.
- R8: A count write of zero makes busy, ext_rd and ext_wr low on the next cycle, and no irq follows.
- R9: Writes to the byte address, internal address, control or wait registers while busy are ignored. After completion the byte address continues from where the transfer ended.
- R10: A transfer of N words with B bytes per word completes in N*(B*(W+1)+1) cycles inbound and N*(B*(W+1)+2) cycles outbound, counted from the count write edge to the cycle in which irq is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 byte addr, 1 internal addr, 2 control, 3 wait, 4 count) |
| reg_wdata | input | 24 | Register write data |
| busy | output | 1 | Transfer in progress |
| words_left | output | CNT_W | Remaining word count |
| irq | output | 1 | One-cycle completion pulse |
| ext_addr | output | BA_W | External byte address |
| ext_rd | output | 1 | External byte read strobe |
| ext_wr | output | 1 | External byte write strobe |
| ext_wdata | output | 8 | External write byte |
| ext_rdata | input | 8 | External read byte, sampled in the last strobe cycle |
| mem_addr | output | IA_W | Internal word address |
| mem_re | output | 1 | Internal read request, data due the next cycle |
| mem_we | output | 1 | Internal word write |
| mem_wdata | output | 24 | Internal write word |
| mem_rdata | input | 24 | Internal read word |

## Verification
The assertions assume that the external byte memory answers within the strobe window and that internal reads return data exactly one cycle after mem_re. They also assume that the internal port is always granted, because arbitration lies outside this block. The bench meets these assumptions with a combinational byte memory and a registered internal memory model. It never stalls either memory, and it drives register writes only between clock edges. It sweeps both directions, both word widths, wait counts 0 to 3 and word counts 1 to 3. Separate runs cover aborts and writes made while busy.

// File: rtl/bytemem_xfer.sv
module bytemem_xfer #(
  parameter int BA_W  = 22,
  parameter int IA_W  = 14,
  parameter int CNT_W = 14,
  parameter int WS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_sel,
  input  logic [23:0]      reg_wdata,
  output logic             busy,
  output logic [CNT_W-1:0] words_left,
  output logic             irq,
  output logic [BA_W-1:0]  ext_addr,
  output logic             ext_rd,
  output logic             ext_wr,
  output logic [7:0]       ext_wdata,
  input  logic [7:0]       ext_rdata,
  output logic [IA_W-1:0]  mem_addr,
  output logic             mem_re,
  output logic             mem_we,
  output logic [23:0]      mem_wdata,
  input  logic [23:0]      mem_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LOAD, S_XFER, S_STORE} state_t;

  state_t           state;
  logic [BA_W-1:0]  baddr;
  logic [IA_W-1:0]  iaddr;
  logic             dir_out, wide;
  logic [WS_W-1:0]  wait_q, wcnt;
  logic [CNT_W-1:0] count;
  logic [1:0]       bidx;
  logic [23:0]      sh;
  logic             irq_q;

  wire count_wr  = reg_wr && reg_sel == 3'd4;
  wire cfg_wr    = reg_wr && state == S_IDLE;
  wire last_byte = bidx == (wide ? 2'd2 : 2'd1);
  wire byte_done = state == S_XFER && wcnt == wait_q;

  assign busy       = state != S_IDLE;
  assign words_left = count;
  assign irq        = irq_q;
  assign ext_addr   = baddr;
  assign ext_rd     = state == S_XFER && !dir_out;
  assign ext_wr     = state == S_XFER && dir_out;
  assign ext_wdata  = sh[23:16];
  assign mem_addr   = iaddr;
  assign mem_re     = state == S_FETCH;
  assign mem_we     = state == S_STORE;
  assign mem_wdata  = wide ? sh : {8'h00, sh[15:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      baddr   <= '0;
      iaddr   <= '0;
      dir_out <= 1'b0;
      wide    <= 1'b0;
      wait_q  <= '0;
      wcnt    <= '0;
      count   <= '0;
      bidx    <= '0;
      sh      <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (count_wr) begin
        count <= reg_wdata[CNT_W-1:0];
        if (reg_wdata[CNT_W-1:0] == '0) begin
          state <= S_IDLE;
        end else if (state == S_IDLE) begin
          state <= dir_out ? S_FETCH : S_XFER;
          bidx  <= '0;
          wcnt  <= '0;
        end
      end else begin
        if (cfg_wr) begin
          case (reg_sel)
            3'd0: baddr <= reg_wdata[BA_W-1:0];
            3'd1: iaddr <= reg_wdata[IA_W-1:0];
            3'd2: begin dir_out <= reg_wdata[0]; wide <= reg_wdata[1]; end
            3'd3: wait_q <= reg_wdata[WS_W-1:0];
            default: ;
          endcase
        end
        case (state)
          S_FETCH: state <= S_LOAD;
          S_LOAD: begin
            sh    <= wide ? mem_rdata : {mem_rdata[15:0], 8'h00};
            state <= S_XFER;
          end
          S_XFER: begin
            if (byte_done) begin
              wcnt  <= '0;
              baddr <= baddr + 1'b1;
              bidx  <= last_byte ? 2'd0 : bidx + 2'd1;
              sh    <= dir_out ? {sh[15:0], 8'h00} : {sh[15:0], ext_rdata};
              if (last_byte) begin
                if (!dir_out) begin
                  state <= S_STORE;
                end else begin
                  iaddr <= iaddr + 1'b1;
                  count <= count - 1'b1;
                  if (count == 1) begin
                    state <= S_IDLE;
                    irq_q <= 1'b1;
                  end else begin
                    state <= S_FETCH;
                  end
                end
              end
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
          S_STORE: begin
            iaddr <= iaddr + 1'b1;
            count <= count - 1'b1;
            if (count == 1) begin
              state <= S_IDLE;
              irq_q <= 1'b1;
            end else begin
              state <= S_XFER;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_rd && ext_wr));

  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd || ext_wr) && wcnt != '0 |-> $stable(ext_addr));

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    count_wr && reg_wdata[CNT_W-1:0] != '0 |=> busy);

  a_r6_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && !count_wr |=> baddr == $past(baddr) + 1'b1);

  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r7_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy && words_left == '0);

  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    count_wr && reg_wdata[CNT_W-1:0] == '0 |=> !busy && !ext_rd && !ext_wr && !irq);

  a_r9_wait_locked: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_sel == 3'd3 && busy |=> $stable(wait_q));

endmodule

// File: tb/bytemem_xfer_test.sv
module bytemem_xfer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [23:0] reg_wdata = '0;
  logic        busy, irq, ext_rd, ext_wr, mem_re, mem_we;
  logic [13:0] words_left;
  logic [21:0] ext_addr;
  logic [7:0]  ext_wdata, ext_rdata;
  logic [13:0] mem_addr;
  logic [23:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  bytemem_xfer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .busy(busy), .words_left(words_left), .irq(irq), .ext_addr(ext_addr),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  localparam logic [13:0] HI = 14'h2A5;

  int nvec = 0, nbad = 0, cyc = 0, up_err = 0, irq_cnt = 0;
  logic clr = 1'b0;
  logic [7:0]  bout [256];
  int          hits [256];
  logic [23:0] imem [64];

  function automatic logic [7:0] fb(int a);
    return 8'((a * 29 + 91) & 255);
  endfunction

  function automatic logic [23:0] gw(int i);
    return {8'(i * 7 + 3), 8'(i * 13 + 64), 8'(i * 5 + 145)};
  endfunction

  assign ext_rdata = fb(int'(ext_addr[7:0]));

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 256; i++) begin bout[i] <= 8'h00; hits[i] <= 0; end
      for (int i = 0; i < 64; i++) imem[i] <= gw(i);
      up_err <= 0;
      irq_cnt <= 0;
    end else begin
      if (ext_rd || ext_wr) begin
        hits[ext_addr[7:0]] <= hits[ext_addr[7:0]] + 1;
        if (ext_addr[21:8] != HI) up_err <= up_err + 1;
      end
      if (ext_wr) bout[ext_addr[7:0]] <= ext_wdata;
      if (mem_we) imem[mem_addr[5:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= imem[mem_addr[5:0]];
      if (irq) irq_cnt <= irq_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] s, input logic [23:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic clear_models();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic run(input int dir, input int wide, input int w, input int n);
    int b, t, k, bl, ia;
    bit fail;
    b = wide ? 3 : 2;
    bl = 32 + n;
    ia = 4 + w;
    t = n * (b * (w + 1) + (dir ? 2 : 1));
    clear_models();
    wreg(3'd0, {2'b0, HI, 8'(bl)});
    wreg(3'd1, 24'(ia));
    wreg(3'd2, 24'(wide * 2 + dir));
    wreg(3'd3, 24'(w));
    wreg(3'd4, 24'(n));
    k = 0;
    while (!irq && k < 400) begin @(negedge clk); k++; end
    check(k == t, "R10 cycles", k, t);
    check(!busy && words_left == 0, "R7 idle at irq", {busy, words_left}, 0);
    @(negedge clk);
    check(!irq, "R7 irq single cycle", irq, 0);
    check(irq_cnt == 1, "R7 irq count", irq_cnt, 1);
    check(up_err == 0, "R6 upper byte address bits", up_err, 0);
    fail = 0;
    for (int j = 0; j < n * b; j++) if (hits[(bl + j) & 255] != w + 1) fail = 1;
    check(!fail, "R3 strobe cycles per byte", fail, 0);
    check(hits[(bl + n * b) & 255] == 0, "R6 no byte past end", hits[(bl + n * b) & 255], 0);
    if (!dir) begin
      for (int q = 0; q < n; q++) begin
        logic [23:0] e;
        int a;
        a = bl + q * b;
        e = wide ? {fb(a), fb(a + 1), fb(a + 2)} : {8'h00, fb(a), fb(a + 1)};
        check(imem[(ia + q) & 63] == e, "R4 packed word", imem[(ia + q) & 63], e);
      end
      check(imem[(ia + n) & 63] == gw(ia + n), "R6 no word past end", imem[(ia + n) & 63], gw(ia + n));
    end else begin
      for (int j = 0; j < n * b; j++) begin
        logic [23:0] wd;
        logic [7:0] e;
        int p;
        wd = gw(ia + j / b);
        p = (b - 1) - (j % b);
        e = wd[p * 8 +: 8];
        check(bout[(bl + j) & 255] == e, "R5 unpacked byte", bout[(bl + j) & 255], e);
      end
    end
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    check(!busy && !irq && !ext_rd && !ext_wr && !mem_re && !mem_we && words_left == 0,
          "R1 reset state", {busy, irq, ext_rd, ext_wr, mem_re, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !irq && !ext_rd && !ext_wr, "R1 idle after reset", {busy, irq, ext_rd, ext_wr}, 0);

    for (int dir = 0; dir < 2; dir++)
      for (int wide = 0; wide < 2; wide++)
        for (int w = 0; w < 4; w++)
          for (int n = 1; n < 4; n++)
            run(dir, wide, w, n);

    // R2 start, busy, words_left; R8 abort
    clear_models();
    wreg(3'd0, {2'b0, HI, 8'h40});
    wreg(3'd1, 24'd10);
    wreg(3'd2, 24'd2);
    wreg(3'd3, 24'd2);
    wreg(3'd4, 24'd5);
    check(busy && words_left == 5, "R2 busy after start", {busy, words_left}, {1'b1, 14'd5});
    check(ext_rd, "R2 first read strobe", ext_rd, 1);
    repeat (11) @(negedge clk);
    check(busy && words_left == 4, "R2 words_left after one word", words_left, 4);
    wreg(3'd4, 24'd0);
    check(!busy && !ext_rd && !ext_wr, "R8 stopped after abort", {busy, ext_rd, ext_wr}, 0);
    repeat (20) @(negedge clk);
    check(irq_cnt == 0 && !busy, "R8 no irq after abort", irq_cnt, 0);

    // R9 writes while busy ignored
    clear_models();
    wreg(3'd0, {2'b0, HI, 8'h20});
    wreg(3'd1, 24'd8);
    wreg(3'd2, 24'd0);
    wreg(3'd3, 24'd0);
    wreg(3'd4, 24'd2);
    wreg(3'd0, {2'b0, HI, 8'h80});
    wreg(3'd3, 24'd7);
    k = 0;
    while (busy && k < 100) begin @(negedge clk); k++; end
    check(hits[8'h80] == 0, "R9 byte address write ignored", hits[8'h80], 0);
    check(imem[9] == {8'h00, fb(8'h22), fb(8'h23)}, "R9 data from original address",
          imem[9], {8'h00, fb(8'h22), fb(8'h23)});
    wreg(3'd4, 24'd1);
    k = 0;
    while (busy && k < 100) begin @(negedge clk); k++; end
    check(hits[8'h24] == 1 && hits[8'h25] == 1, "R9 wait write ignored, address continues",
          hits[8'h24], 1);
    check(imem[10] == {8'h00, fb(8'h24), fb(8'h25)}, "R9 continued word", imem[10],
          {8'h00, fb(8'h24), fb(8'h25)});

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule